// File: doc/BRIEF.md
# Serial DAC Command Frame Receiver

This block accepts 24-bit command frames over a three-wire serial link: an active-low frame-select line, a serial clock and a serial data input. It lives entirely in the serial clock domain. Every falling clock edge while frame-select is low shifts one bit in, most significant bit first. Frame-select acts as an asynchronous clear for the bit counter, the shift register and the strobe.

When the 24th bit has been captured, the block raises a valid strobe for one serial-clock period. It then holds the command, channel address and data code on parallel outputs until frame-select is released. The link master can abort a frame by releasing frame-select early. Further clock edges after a complete frame are ignored until frame-select has gone high and then low again. A parameter picks the converter resolution, which sets how many of the 16 data-word bits make up the code.

Top module: `dac_frame_rx`

## Requirements
- R1: While frame-select (`sel_n`) is high, the strobe `frame_valid` is 0 and `cmd_o`, `addr_o` and `code_o` are all 0.
- R2: Bits are sampled from `sdi` on falling `sclk` edges while `sel_n` is low, the first bit being frame bit 23. Frame bits 21..19 form the command, bits 18..16 the address and bits 15..0 the data word.
- R3: `frame_valid` rises on the 24th falling edge of a frame and falls on the next falling edge, so it lasts exactly one `sclk` period.
- R4: From the 24th falling edge until `sel_n` rises, `cmd_o`, `addr_o` and `code_o` present the captured fields without change. Before the 24th edge they read 0.
- R5: Raising `sel_n` before the 24th falling edge aborts the frame. No strobe is produced, and the bits already received do not affect the next frame.
- R6: Falling `sclk` edges after the 24th, while `sel_n` stays low, change no output and produce no second strobe.
- R7: A new frame is captured only after `sel_n` has gone high and then low again.
- R8: With resolution parameter `RES_BITS` (12, 14 or 16), `code_o` equals the top `RES_BITS` bits of the data word (frame bits 15 down to 16-`RES_BITS`). The remaining low bits are ignored.
- R9: Frame bits 23 and 22 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| sel_n | input | 1 | Active-low frame select; high clears the receiver asynchronously |
| sdi | input | 1 | Serial data, most significant bit first |
| frame_valid | output | 1 | One-period strobe marking a completed frame |
| cmd_o | output | 3 | Command field of the completed frame |
| addr_o | output | 3 | Address field of the completed frame |
| code_o | output | RES_BITS | Data code of the completed frame |

## Verification
The bench releases frame-select after 10 and after 23 bits. A receiver with an off-by-one counter would emit a strobe on the aborted 23-bit frame, and one that kept stale bits would corrupt the following frame. After a complete frame, the bench keeps clocking with frame-select held low and inverted data on the line. A receiver that failed to freeze would change its fields or pulse a second strobe. Two frames that differ only in the leading don't-care bits and the sub-resolution bits are sent to a 12-bit instance, which must report identical codes.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  localparam int unsigned FRAME_BITS = 24;
  localparam int unsigned CMD_W      = 3;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned CMD_LSB    = WORD_W + ADDR_W;
  localparam int unsigned ADDR_LSB   = WORD_W;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] word;
  } frame_fields_t;

  // Pull the fields out of a complete frame; the two leading bits are dropped.
  function automatic frame_fields_t split_frame(input logic [FRAME_BITS-1:0] f);
    frame_fields_t r;
    r.cmd  = f[CMD_LSB  +: CMD_W];
    r.addr = f[ADDR_LSB +: ADDR_W];
    r.word = f[0        +: WORD_W];
    return r;
  endfunction

  // Right-justify the left-aligned code of a converter with res bits.
  function automatic logic [WORD_W-1:0] align_code(input logic [WORD_W-1:0] w,
                                                   input int unsigned res);
    return w >> (WORD_W - res);
  endfunction

endpackage

// File: rtl/dfr_counter.sv
module dfr_counter #(
  parameter int unsigned NBITS = 24,
  localparam int unsigned CNT_W = $clog2(NBITS + 1)
) (
  input  logic sclk,
  input  logic sel_n,
  output logic accept,
  output logic last_edge,
  output logic full
);

  logic [CNT_W-1:0] cnt;

  assign accept    = (cnt != CNT_W'(NBITS));
  assign last_edge = (cnt == CNT_W'(NBITS - 1));
  assign full      = (cnt == CNT_W'(NBITS));

  always_ff @(negedge sclk or posedge sel_n) begin
    if (sel_n)       cnt <= '0;
    else if (accept) cnt <= cnt + 1'b1;
  end

  // R2: each accepted edge advances the bit count by exactly one
  a_r2_count_step: assert property (@(negedge sclk) disable iff (sel_n)
    accept |=> (cnt == $past(cnt) + 1'b1));

  // R6: once full, the count stays full until frame-select is released
  a_r6_count_saturates: assert property (@(negedge sclk) disable iff (sel_n)
    full |=> full);

  // R4: count never passes the frame length
  a_r4_count_bounded: assert property (@(negedge sclk) disable iff (sel_n)
    cnt <= CNT_W'(NBITS));

endmodule

// File: rtl/dfr_shifter.sv
module dfr_shifter #(
  parameter int unsigned NBITS = 24
) (
  input  logic             sclk,
  input  logic             sel_n,
  input  logic             sdi,
  input  logic             shift_en,
  output logic [NBITS-1:0] frame
);

  always_ff @(negedge sclk or posedge sel_n) begin
    if (sel_n)         frame <= '0;
    else if (shift_en) frame <= {frame[NBITS-2:0], sdi};
  end

  // R2: the newest bit enters at the bottom, so the first bit ends on top
  a_r2_msb_first: assert property (@(negedge sclk) disable iff (sel_n)
    shift_en |=> (frame[0] == $past(sdi)));

  // R6: with shifting disabled the register is frozen
  a_r6_frozen: assert property (@(negedge sclk) disable iff (sel_n)
    !shift_en |=> $stable(frame));

endmodule

// File: rtl/dfr_decode.sv
module dfr_decode
  import dfr_pkg::*;
#(
  parameter int unsigned RES_BITS = 16
) (
  input  logic                  sclk,
  input  logic                  sel_n,
  input  logic                  last_edge,
  input  logic                  full,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  valid,
  output logic [CMD_W-1:0]      cmd,
  output logic [ADDR_W-1:0]     addr,
  output logic [RES_BITS-1:0]   code
);

  frame_fields_t fld;

  always_ff @(negedge sclk or posedge sel_n) begin
    if (sel_n) valid <= 1'b0;
    else       valid <= last_edge;
  end

  always_comb begin
    fld = full ? split_frame(frame) : '0;
  end

  assign cmd  = fld.cmd;
  assign addr = fld.addr;

  generate
    if (RES_BITS == WORD_W) begin : g_full_res
      assign code = fld.word;
    end else begin : g_part_res
      assign code = RES_BITS'(align_code(fld.word, RES_BITS));
    end
  endgenerate

  // R3: the strobe never lasts past one serial-clock period
  a_r3_one_period: assert property (@(negedge sclk) disable iff (sel_n)
    valid |=> !valid);

  // R3: the strobe only appears with a complete frame held
  a_r3_with_full: assert property (@(negedge sclk) disable iff (sel_n)
    valid |-> full);

  // R4: the presented fields stay fixed once the frame is complete
  a_r4_fields_hold: assert property (@(negedge sclk) disable iff (sel_n)
    full |=> $stable({cmd, addr, code}));

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dfr_pkg::*;
#(
  parameter int unsigned RES_BITS = 16
) (
  input  logic                sclk,
  input  logic                sel_n,
  input  logic                sdi,
  output logic                frame_valid,
  output logic [2:0]          cmd_o,
  output logic [2:0]          addr_o,
  output logic [RES_BITS-1:0] code_o
);

  logic                  accept;
  logic                  last_edge;
  logic                  full;
  logic [FRAME_BITS-1:0] frame;

  dfr_counter #(.NBITS(FRAME_BITS)) u_count (
    .sclk      (sclk),
    .sel_n     (sel_n),
    .accept    (accept),
    .last_edge (last_edge),
    .full      (full)
  );

  dfr_shifter #(.NBITS(FRAME_BITS)) u_shift (
    .sclk     (sclk),
    .sel_n    (sel_n),
    .sdi      (sdi),
    .shift_en (accept),
    .frame    (frame)
  );

  dfr_decode #(.RES_BITS(RES_BITS)) u_decode (
    .sclk      (sclk),
    .sel_n     (sel_n),
    .last_edge (last_edge),
    .full      (full),
    .frame     (frame),
    .valid     (frame_valid),
    .cmd       (cmd_o),
    .addr      (addr_o),
    .code      (code_o)
  );

  // R5: a strobe implies the previous edge was the last of a frame still selected
  a_r5_strobe_needs_frame: assert property (@(negedge sclk) disable iff (sel_n)
    $rose(frame_valid) |-> full);

endmodule

// File: tb/dac_frame_rx_tb.sv
module dac_frame_rx_tb;

  localparam int CLK_PERIOD = 20;

  logic        sclk = 1'b1;
  logic        sel_n = 1'b1;
  logic        sdi = 1'b0;
  logic        frame_valid, frame_valid12;
  logic [2:0]  cmd_o, addr_o, cmd12, addr12;
  logic [15:0] code_o;
  logic [11:0] code12;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  dac_frame_rx u_dut (
    .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
    .frame_valid(frame_valid), .cmd_o(cmd_o), .addr_o(addr_o), .code_o(code_o)
  );

  dac_frame_rx #(.RES_BITS(12)) u_dut12 (
    .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
    .frame_valid(frame_valid12), .cmd_o(cmd12), .addr_o(addr12), .code_o(code12)
  );

  always @(posedge sclk) if (frame_valid) strobes++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive n bits of f, first bit 23; returns at the rising edge after the n-th fall.
  task automatic clock_bits(input logic [23:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge sclk);
      sel_n = 1'b0;
      sdi   = f[23-i];
    end
    @(posedge sclk);
  endtask

  task automatic release_sel();
    sel_n = 1'b1;
    @(posedge sclk);
  endtask

  task automatic t_reset();
    sel_n = 1'b1;
    repeat (3) @(posedge sclk);
    chk(frame_valid == 1'b0, "R1 strobe idle", 32'(frame_valid), 0);
    chk({cmd_o, addr_o, code_o} == '0, "R1 fields idle", {cmd_o, addr_o, code_o}, 0);
  endtask

  task automatic t_frame(input logic [23:0] f);
    int s0 = strobes;
    logic [2:0]  ec = f[21:19];
    logic [2:0]  ea = f[18:16];
    logic [15:0] ew = f[15:0];
    clock_bits(f, 24);
    chk(frame_valid == 1'b1, "R3 strobe after 24th edge", 32'(frame_valid), 1);
    chk(cmd_o == ec, "R2 command field", 32'(cmd_o), 32'(ec));
    chk(addr_o == ea, "R2 address field", 32'(addr_o), 32'(ea));
    chk(code_o == ew, "R2 data word", 32'(code_o), 32'(ew));
    chk(code12 == ew[15:4], "R8 12-bit code", 32'(code12), 32'(ew[15:4]));
    sdi = ~sdi;
    @(posedge sclk);
    chk(frame_valid == 1'b0, "R3 strobe one period", 32'(frame_valid), 0);
    chk({cmd_o, addr_o, code_o} == {ec, ea, ew}, "R4 fields held",
        {cmd_o, addr_o, code_o}, {ec, ea, ew});
    clock_bits(~f, 24);
    chk({cmd_o, addr_o, code_o} == {ec, ea, ew}, "R6 extra edges ignored",
        {cmd_o, addr_o, code_o}, {ec, ea, ew});
    chk(strobes == s0 + 1, "R7 no second strobe without re-arm", 32'(strobes), 32'(s0 + 1));
    release_sel();
    chk({cmd_o, addr_o, code_o} == '0, "R1 fields cleared on release",
        {cmd_o, addr_o, code_o}, 0);
  endtask

  task automatic t_abort(input int n);
    int s0 = strobes;
    clock_bits(24'hFFFFFF, n);
    release_sel();
    @(posedge sclk);
    chk(strobes == s0, "R5 aborted frame gives no strobe", 32'(strobes), 32'(s0));
    chk(frame_valid == 1'b0, "R5 strobe low after abort", 32'(frame_valid), 0);
    t_frame(24'h0A_5A3C);
  endtask

  task automatic t_dont_care();
    logic [11:0] first;
    logic [2:0]  c1;
    clock_bits(24'h3F_ABCF, 24);
    first = code12;
    c1    = cmd12;
    release_sel();
    clock_bits(24'h3F_ABC0 & 24'h3F_FFFF, 24);
    chk(code12 == first, "R8 low bits ignored", 32'(code12), 32'(first));
    release_sel();
    clock_bits(24'hFF_ABCF, 24);
    chk(cmd12 == c1, "R9 leading bits ignored (cmd)", 32'(cmd12), 32'(c1));
    chk(code12 == first, "R9 leading bits ignored (code)", 32'(code12), 32'(first));
    release_sel();
  endtask

  initial begin
    repeat (20000) @(posedge sclk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame(24'h19_1234);
    t_frame(24'h26_FFFF);
    t_frame(24'h00_0001);
    t_abort(10);
    t_abort(23);
    t_dont_care();
    t_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule